// File: doc/BRIEF.md
# Indirect Register Gateway

The gateway is a window of 32-bit registers that sits behind a dword-wide configuration read/write port. Software reaches a larger internal store through it by indirection: it selects an address space in the control register, loads the data register, and writes the address register to start a transfer. The gateway then runs the transfer against an internal word store with a fixed, parameterised latency. One flag bit reports completion. For a write the flag falls when the transfer finishes. For a read the flag rises when the data register holds the result.

Several agents share the window, so ownership is arbitrated by a ticket scheme. Each read of the counter register returns a distinct nonzero ticket. An agent writes its ticket into the semaphore and reads it back, and it owns the gateway only if the value it reads back is its own. Reads also report the next readable address, so that a sparse space can be walked without stepping on holes. Space 0 is dense with 4-byte steps. Space 1 holds one entry per 8 bytes.

Top module: `regwin_gateway`

## Requirements
- R1: The ticket register at offset 0x8 resets to 1. Each configuration read of it returns the current value and then advances it by one, skipping zero. Writes to it have no effect.
- R2: The semaphore at offset 0xC resets to 0. A nonzero write is stored only while the semaphore reads 0. A nonzero write while it holds a nonzero value leaves it unchanged.
- R3: Writing 0 to the semaphore clears it, whatever it held.
- R4: Control register 0x4: bits 15:0 hold the selected space. Bits 31:29 read 3'b001 when that space is below NUM_SPACES and 3'b000 otherwise. Bit 28 reads 1 exactly when the space is supported. Bits 27:16 read 0. After reset space 0 is selected, so the register reads 0x3000_0000.
- R5: A control write that selects a supported space loads bits 29:0 of the address register with that space's size in bytes (DEPTH_WORDS*4). A control write that selects an unsupported space leaves the address field alone.
- R6: Address register 0x10 has the flag in bit 31, the syndrome in bit 30 and the address in bits 29:0. A write with bit 30 set, or made while the selected space is unsupported, starts nothing and sets the syndrome. The next accepted request clears the syndrome.
- R7: Writing the address register with bit 31 = 1 starts a store of the data register. The flag reads 1 for LATENCY cycles and then 0, and the address field is kept. The flag reads 0 after reset.
- R8: Writing the address register with bit 31 = 0 starts a load. The flag reads 0 for LATENCY cycles and then 1, with data register 0x14 holding the stored word. An address at or beyond the space size reads as 0.
- R9: When a load completes, the address field holds the next readable address, which is strictly greater than the one read. That address is the next multiple of 4 in space 0 and the next multiple of 8 in space 1.
- R10: While a transfer is in flight, including its completion cycle, writes to the address, data and control registers are ignored. A data write one cycle after completion is taken.
- R11: Reads of unmapped offsets (such as 0x0 and 0x18) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_req | input | 1 | Configuration access strobe, one cycle per access |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_off | input | 5 | Byte offset within the window |
| cfg_wdata | input | 32 | Write data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| cfg_rdata | output | 32 | Registered read data |

## Verification
The completion of a transfer and a configuration write to the data or address register can land on the same clock edge. The completion wins, and the write is dropped because the block is still busy on that edge. The bench issues a load, counts LATENCY edges from the start, and then places a data write exactly on the completion edge. It passes only if the data register afterwards holds the stored word rather than the written one. A second data write one edge later must be taken, which shows that the busy window closes on exactly the right cycle.

// File: rtl/gw_pkg.sv
// Shared constants for the register gateway: window offsets, field positions
// of the address/flag register and the transfer direction type.
package gw_pkg;
    localparam int unsigned WORD_W       = 32;
    localparam int unsigned OFF_W        = 5;
    localparam int unsigned SPACE_W      = 16;
    localparam int unsigned AFIELD_W     = 30;
    localparam int unsigned FLAG_BIT     = 31;
    localparam int unsigned SYND_BIT     = 30;

    localparam logic [OFF_W-1:0] OFF_CTRL   = 5'h04;
    localparam logic [OFF_W-1:0] OFF_TICKET = 5'h08;
    localparam logic [OFF_W-1:0] OFF_SEM    = 5'h0C;
    localparam logic [OFF_W-1:0] OFF_ADDR   = 5'h10;
    localparam logic [OFF_W-1:0] OFF_DATA   = 5'h14;

    typedef enum logic {
        DIR_LOAD  = 1'b0,
        DIR_STORE = 1'b1
    } gw_dir_e;
endpackage

// File: rtl/gw_ticket_sem.sv
// Ticket counter and ownership semaphore.
// Assumes: tick_rd pulses once per configuration read of the ticket register;
// sem_we pulses once per configuration write of the semaphore. CNT_W <= 32.
module gw_ticket_sem
    import gw_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_rd,
    input  logic              sem_we,
    input  logic [WORD_W-1:0] sem_wdata,
    output logic [WORD_W-1:0] ticket,
    output logic [WORD_W-1:0] sem
);
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_inc;
    logic [WORD_W-1:0] sem_q;

    // Next ticket value, stepping over zero on wrap.
    always_comb begin
        cnt_inc = cnt_q + CNT_W'(1);
        if (cnt_inc == '0) cnt_inc = CNT_W'(1);
    end

    // Ticket counter advances on each read.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= CNT_W'(1);
        else if (tick_rd) cnt_q <= cnt_inc;
    end

    // Semaphore: zero releases, nonzero only claims a free semaphore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sem_q <= '0;
        end else if (sem_we) begin
            if (sem_wdata == '0)  sem_q <= '0;
            else if (sem_q == '0) sem_q <= sem_wdata;
        end
    end

    assign ticket = WORD_W'(cnt_q);
    assign sem    = sem_q;

    assert_ticket_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_rd |=> (cnt_q != $past(cnt_q)) && (cnt_q != '0));
    assert_sem_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sem_we && sem_wdata != '0 && sem_q != '0) |=> sem_q == $past(sem_q));
    assert_sem_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sem_we && sem_wdata == '0) |=> sem_q == '0);
endmodule

// File: rtl/gw_backend.sv
// Internal word store behind the gateway, one bank per supported space.
// Assumes: DEPTH_WORDS is a power of two; en is a one-cycle completion pulse.
// Space s steps through addresses in units of (4 << s) bytes.
module gw_backend
    import gw_pkg::*;
#(
    parameter int unsigned NUM_SPACES  = 2,
    parameter int unsigned DEPTH_WORDS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                we,
    input  logic [SPACE_W-1:0]  space,
    input  logic [AFIELD_W-1:0] addr,
    input  logic [WORD_W-1:0]   wdata,
    output logic [WORD_W-1:0]   rdata,
    output logic [AFIELD_W-1:0] next_addr
);
    localparam int unsigned WIDX_W = $clog2(DEPTH_WORDS);
    localparam int unsigned SIDX_W = (NUM_SPACES > 1) ? $clog2(NUM_SPACES) : 1;
    localparam int unsigned IDX_W  = WIDX_W + SIDX_W;
    localparam logic [AFIELD_W-1:0] SIZE_L  = AFIELD_W'(DEPTH_WORDS * 4);
    localparam logic [SPACE_W-1:0]  NSPC_L  = SPACE_W'(NUM_SPACES);

    logic [WORD_W-1:0] mem [0:(1<<IDX_W)-1];
    logic [IDX_W-1:0]  idx;
    logic              in_range;
    logic [4:0]        step_sh;

    // Bank and word index, and whether the access hits stored words.
    always_comb begin
        idx      = {space[SIDX_W-1:0], addr[WIDX_W+1:2]};
        in_range = (addr < SIZE_L) && (space < NSPC_L);
        step_sh  = 5'd2 + 5'(space[SIDX_W-1:0]);
    end

    // Store on a completing write that hits the space.
    always_ff @(posedge clk) begin
        if (en && we && in_range) mem[idx] <= wdata;
    end

    assign rdata     = in_range ? mem[idx] : '0;
    assign next_addr = ((addr >> step_sh) + AFIELD_W'(1)) << step_sh;

    assert_next_ahead_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !we && in_range) |-> next_addr > addr);
endmodule

// File: rtl/gw_engine.sv
// Transfer engine: address/flag/syndrome register, data register, latency
// counter and completion handling. Assumes LATENCY >= 1 and that at most one
// of addr_we, data_we, size_load is high in a cycle.
module gw_engine
    import gw_pkg::*;
#(
    parameter int unsigned LATENCY = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                addr_we,
    input  logic                data_we,
    input  logic                size_load,
    input  logic [WORD_W-1:0]   wdata,
    input  logic                space_ok,
    input  logic [AFIELD_W-1:0] space_size,
    output logic                busy,
    output logic [WORD_W-1:0]   addr_reg,
    output logic [WORD_W-1:0]   data_reg,
    output logic                be_en,
    output logic                be_we,
    output logic [AFIELD_W-1:0] be_addr,
    output logic [WORD_W-1:0]   be_wdata,
    input  logic [WORD_W-1:0]   be_rdata,
    input  logic [AFIELD_W-1:0] be_next
);
    localparam int unsigned LAT_W = $clog2(LATENCY + 1);

    logic                busy_q, flag_q, synd_q;
    gw_dir_e             dir_q;
    logic [LAT_W-1:0]    lat_q;
    logic [AFIELD_W-1:0] afield_q;
    logic [WORD_W-1:0]   data_q;
    logic                take_req, start, done;

    // Request acceptance and completion strobes.
    always_comb begin
        take_req = addr_we && !busy_q;
        start    = take_req && !wdata[SYND_BIT] && space_ok;
        done     = busy_q && (lat_q == '0);
    end

    // Transfer state: busy window, flag, syndrome and address field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            flag_q   <= 1'b0;
            synd_q   <= 1'b0;
            dir_q    <= DIR_LOAD;
            lat_q    <= '0;
            afield_q <= '0;
        end else begin
            if (done) begin
                busy_q <= 1'b0;
                flag_q <= (dir_q == DIR_LOAD);
                if (dir_q == DIR_LOAD) afield_q <= be_next;
            end else if (busy_q) begin
                lat_q <= lat_q - LAT_W'(1);
            end
            if (start) begin
                busy_q   <= 1'b1;
                lat_q    <= LAT_W'(LATENCY - 1);
                dir_q    <= gw_dir_e'(wdata[FLAG_BIT]);
                flag_q   <= wdata[FLAG_BIT];
                synd_q   <= 1'b0;
                afield_q <= wdata[AFIELD_W-1:0];
            end else if (take_req) begin
                synd_q <= 1'b1;
            end
            if (size_load && !busy_q) afield_q <= space_size;
        end
    end

    // Data register: loads from software when idle, from the store on a load.
    always_ff @(posedge clk) begin
        if (!rst_n)                          data_q <= '0;
        else if (done && dir_q == DIR_LOAD)  data_q <= be_rdata;
        else if (data_we && !busy_q)         data_q <= wdata;
    end

    assign busy     = busy_q;
    assign addr_reg = {flag_q, synd_q, afield_q};
    assign data_reg = data_q;
    assign be_en    = done;
    assign be_we    = (dir_q == DIR_STORE);
    assign be_addr  = afield_q;
    assign be_wdata = data_q;

    assert_size_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (size_load && !busy_q) |=> afield_q == $past(space_size));
    assert_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req && (wdata[SYND_BIT] || !space_ok)) |=> (!busy_q && synd_q));
    assert_store_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dir_q == DIR_STORE) |=> !flag_q);
    assert_load_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dir_q == DIR_LOAD) |=> flag_q);
    assert_busy_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && lat_q != '0 && data_we) |=> $stable(data_q));
    assert_busy_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && lat_q != '0 && addr_we) |=> $stable(afield_q));
endmodule

// File: rtl/regwin_gateway.sv
// Indirect register gateway top: decodes the configuration window, holds the
// space-select control register and registers read data for one cycle.
// Assumes cfg_req is a single-cycle strobe per access.
module regwin_gateway
    import gw_pkg::*;
#(
    parameter int unsigned NUM_SPACES  = 2,
    parameter int unsigned DEPTH_WORDS = 16,
    parameter int unsigned LATENCY     = 4,
    parameter int unsigned CNT_W       = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_req,
    input  logic              cfg_wr,
    input  logic [OFF_W-1:0]  cfg_off,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic              cfg_rvalid,
    output logic [WORD_W-1:0] cfg_rdata
);
    localparam logic [SPACE_W-1:0]  NSPC_L = SPACE_W'(NUM_SPACES);
    localparam logic [AFIELD_W-1:0] SIZE_L = AFIELD_W'(DEPTH_WORDS * 4);

    logic                hit_ctrl, hit_tick, hit_sem, hit_addr, hit_data, rd;
    logic [SPACE_W-1:0]  space_q;
    logic                space_ok, busy;
    logic [WORD_W-1:0]   ctrl_val, ticket, sem, addr_reg, data_reg, rd_mux;
    logic                be_en, be_we;
    logic [AFIELD_W-1:0] be_addr, be_next;
    logic [WORD_W-1:0]   be_wdata, be_rdata;
    logic                rvalid_q, rd_ctrl_q, rd_unmapped_q;
    logic [WORD_W-1:0]   rdata_q;

    // Offset decode.
    always_comb begin
        hit_ctrl = cfg_req && (cfg_off == OFF_CTRL);
        hit_tick = cfg_req && (cfg_off == OFF_TICKET);
        hit_sem  = cfg_req && (cfg_off == OFF_SEM);
        hit_addr = cfg_req && (cfg_off == OFF_ADDR);
        hit_data = cfg_req && (cfg_off == OFF_DATA);
        rd       = cfg_req && !cfg_wr;
    end

    // Space select, held while a transfer is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)                          space_q <= '0;
        else if (hit_ctrl && cfg_wr && !busy) space_q <= cfg_wdata[SPACE_W-1:0];
    end

    assign space_ok = (space_q < NSPC_L);
    assign ctrl_val = {(space_ok ? 3'b001 : 3'b000), space_ok, 12'd0, space_q};

    gw_ticket_sem #(.CNT_W(CNT_W)) i_ticket_sem (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_rd   (hit_tick && !cfg_wr),
        .sem_we    (hit_sem && cfg_wr),
        .sem_wdata (cfg_wdata),
        .ticket    (ticket),
        .sem       (sem)
    );

    gw_engine #(.LATENCY(LATENCY)) i_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_we    (hit_addr && cfg_wr),
        .data_we    (hit_data && cfg_wr),
        .size_load  (hit_ctrl && cfg_wr && (cfg_wdata[SPACE_W-1:0] < NSPC_L)),
        .wdata      (cfg_wdata),
        .space_ok   (space_ok),
        .space_size (SIZE_L),
        .busy       (busy),
        .addr_reg   (addr_reg),
        .data_reg   (data_reg),
        .be_en      (be_en),
        .be_we      (be_we),
        .be_addr    (be_addr),
        .be_wdata   (be_wdata),
        .be_rdata   (be_rdata),
        .be_next    (be_next)
    );

    gw_backend #(.NUM_SPACES(NUM_SPACES), .DEPTH_WORDS(DEPTH_WORDS)) i_backend (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (be_en),
        .we        (be_we),
        .space     (space_q),
        .addr      (be_addr),
        .wdata     (be_wdata),
        .rdata     (be_rdata),
        .next_addr (be_next)
    );

    // Read-data selection by offset.
    always_comb begin
        unique case (cfg_off)
            OFF_CTRL:   rd_mux = ctrl_val;
            OFF_TICKET: rd_mux = ticket;
            OFF_SEM:    rd_mux = sem;
            OFF_ADDR:   rd_mux = addr_reg;
            OFF_DATA:   rd_mux = data_reg;
            default:    rd_mux = '0;
        endcase
    end

    // Registered read return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q      <= 1'b0;
            rdata_q       <= '0;
            rd_ctrl_q     <= 1'b0;
            rd_unmapped_q <= 1'b0;
        end else begin
            rvalid_q      <= rd;
            rd_ctrl_q     <= rd && hit_ctrl;
            rd_unmapped_q <= rd && !(hit_ctrl || hit_tick || hit_sem || hit_addr || hit_data);
            if (rd) rdata_q <= rd_mux;
        end
    end

    assign cfg_rvalid = rvalid_q;
    assign cfg_rdata  = rdata_q;

    assert_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid_q && rd_ctrl_q) |-> ((rdata_q[31:29] != 3'b000) == (rdata_q[SPACE_W-1:0] < NSPC_L)));
    assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid_q && rd_unmapped_q) |-> rdata_q == '0);
endmodule

// File: tb/test_regwin_gateway.sv
module test_regwin_gateway;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 4;

    localparam logic [4:0] O_CTRL = 5'h04, O_TICK = 5'h08, O_SEM = 5'h0C,
                           O_ADDR = 5'h10, O_DATA = 5'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_req = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [4:0]  cfg_off = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_rvalid;
    logic [31:0] cfg_rdata;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regwin_gateway #(.NUM_SPACES(2), .DEPTH_WORDS(16), .LATENCY(LAT), .CNT_W(32)) i_regwin_gateway (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_wr(cfg_wr),
        .cfg_off(cfg_off), .cfg_wdata(cfg_wdata),
        .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata)
    );

    // Vector: requirement number, write flag, offset, write data or expected read.
    typedef struct packed {
        logic [3:0]  req;
        logic        wr;
        logic [4:0]  off;
        logic [31:0] val;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{4'd4,  1'b0, 5'h04, 32'h3000_0000},  // R4 reset control
        '{4'd7,  1'b0, 5'h10, 32'h0000_0000},  // R7 flag clear at reset
        '{4'd2,  1'b0, 5'h0C, 32'h0000_0000},  // R2 semaphore free
        '{4'd1,  1'b0, 5'h08, 32'h0000_0001},  // R1 first ticket
        '{4'd1,  1'b0, 5'h08, 32'h0000_0002},  // R1 next ticket
        '{4'd2,  1'b1, 5'h0C, 32'h0000_0002},
        '{4'd2,  1'b0, 5'h0C, 32'h0000_0002},  // R2 claimed
        '{4'd2,  1'b1, 5'h0C, 32'h0000_0005},
        '{4'd2,  1'b0, 5'h0C, 32'h0000_0002},  // R2 loser blocked
        '{4'd3,  1'b1, 5'h0C, 32'h0000_0000},
        '{4'd3,  1'b0, 5'h0C, 32'h0000_0000},  // R3 released
        '{4'd2,  1'b1, 5'h0C, 32'h0000_0007},
        '{4'd2,  1'b0, 5'h0C, 32'h0000_0007},  // R2 new owner
        '{4'd3,  1'b1, 5'h0C, 32'h0000_0000},
        '{4'd3,  1'b0, 5'h0C, 32'h0000_0000},  // R3
        '{4'd4,  1'b1, 5'h04, 32'h0000_0001},
        '{4'd4,  1'b0, 5'h04, 32'h3000_0001},  // R4 space 1 supported
        '{4'd5,  1'b0, 5'h10, 32'h0000_0040},  // R5 size loaded
        '{4'd4,  1'b1, 5'h04, 32'h0000_0005},
        '{4'd4,  1'b0, 5'h04, 32'h0000_0005},  // R4 unsupported space
        '{4'd6,  1'b1, 5'h10, 32'h8000_0004},
        '{4'd6,  1'b0, 5'h10, 32'h4000_0040},  // R6 rejected, R5 no load
        '{4'd11, 1'b0, 5'h00, 32'h0000_0000},  // R11
        '{4'd11, 1'b0, 5'h18, 32'h0000_0000},  // R11
        '{4'd5,  1'b1, 5'h04, 32'h0000_0000},
        '{4'd5,  1'b0, 5'h10, 32'h4000_0040},  // R5 reload
        '{4'd6,  1'b1, 5'h10, 32'h4000_0008},
        '{4'd6,  1'b0, 5'h10, 32'h4000_0040},  // R6 syndrome request ignored
        '{4'd1,  1'b1, 5'h08, 32'h0000_0099},
        '{4'd1,  1'b0, 5'h08, 32'h0000_0003},  // R1 write has no effect
        '{4'd10, 1'b1, 5'h14, 32'hCAFE_0001},
        '{4'd10, 1'b0, 5'h14, 32'hCAFE_0001}   // R10 idle data load
    };

    task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Called right after a falling edge; one access per cycle.
    task automatic cfg_write(input logic [4:0] off, input logic [31:0] d);
        cfg_req = 1'b1; cfg_wr = 1'b1; cfg_off = off; cfg_wdata = d;
        @(negedge clk);
        cfg_req = 1'b0; cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [4:0] off, output logic [31:0] d);
        cfg_req = 1'b1; cfg_wr = 1'b0; cfg_off = off;
        @(negedge clk);
        cfg_req = 1'b0;
        d = cfg_rdata;
    endtask

    task automatic wait_done();
        repeat (LAT) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) cfg_write(VECS[i].off, VECS[i].val);
            else begin
                cfg_read(VECS[i].off, r);
                chk(int'(VECS[i].req), r, VECS[i].val, $sformatf("vector %0d", i));
            end
        end

        // R7 store: flag high for LAT cycles, then low; R6 syndrome cleared.
        cfg_write(O_ADDR, 32'h8000_0008);
        for (int k = 1; k <= LAT + 1; k++) begin
            cfg_read(O_ADDR, r);
            chk(7, r, (k <= LAT) ? 32'h8000_0008 : 32'h0000_0008, $sformatf("store flag k=%0d", k));
            if (k == 1) chk(6, {31'd0, r[30]}, 32'd0, "syndrome cleared by accepted request");
        end
        // R8/R9 load: flag low for LAT cycles, then high with next address.
        cfg_write(O_ADDR, 32'h0000_0008);
        for (int k = 1; k <= LAT + 1; k++) begin
            cfg_read(O_ADDR, r);
            chk(8, r, (k <= LAT) ? 32'h0000_0008 : 32'h8000_000C, $sformatf("load flag k=%0d", k));
        end
        cfg_read(O_DATA, r); chk(8, r, 32'hCAFE_0001, "load data");

        // R9 sparse space 1 steps by 8.
        cfg_write(O_CTRL, 32'h0000_0001);
        cfg_read(O_ADDR, r); chk(5, r, 32'h8000_0040, "space 1 size");
        cfg_write(O_DATA, 32'h1111_2222);
        cfg_write(O_ADDR, 32'h8000_0010); wait_done();
        cfg_write(O_ADDR, 32'h0000_0010); wait_done();
        cfg_read(O_ADDR, r); chk(9, r, 32'h8000_0018, "space 1 next address");
        cfg_read(O_DATA, r); chk(8, r, 32'h1111_2222, "space 1 data");
        cfg_write(O_ADDR, 32'h0000_0014); wait_done();
        cfg_read(O_ADDR, r); chk(9, r, 32'h8000_0018, "space 1 mid-stride next");

        // R8 out-of-range load returns zero.
        cfg_write(O_CTRL, 32'h0000_0000);
        cfg_write(O_ADDR, 32'h0000_0040); wait_done();
        cfg_read(O_DATA, r); chk(8, r, 32'h0000_0000, "beyond size");

        // R10 data write on the completion edge is dropped, next edge taken.
        cfg_write(O_DATA, 32'h5555_AAAA);
        cfg_write(O_ADDR, 32'h8000_0020); wait_done();
        cfg_write(O_DATA, 32'h0000_0000);
        cfg_write(O_ADDR, 32'h0000_0020);
        repeat (LAT - 1) @(negedge clk);
        cfg_write(O_DATA, 32'hDEAD_BEEF);
        cfg_read(O_DATA, r); chk(10, r, 32'h5555_AAAA, "write on completion edge");
        cfg_write(O_DATA, 32'h7777_0000);
        cfg_read(O_DATA, r); chk(10, r, 32'h7777_0000, "write after completion");

        // R10 address and control writes during a transfer are dropped.
        cfg_write(O_ADDR, 32'h0000_0020);
        cfg_write(O_ADDR, 32'h8000_0030);
        cfg_write(O_CTRL, 32'h0000_0001);
        wait_done();
        cfg_read(O_ADDR, r); chk(10, r, 32'h8000_0024, "address write while busy");
        cfg_read(O_CTRL, r); chk(10, r, 32'h3000_0000, "control write while busy");

        // Reset mid-use: R2 semaphore, R1 ticket, R7 flag.
        cfg_write(O_SEM, 32'h0000_0009);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cfg_read(O_SEM, r);  chk(2, r, 32'h0000_0000, "semaphore after reset");
        cfg_read(O_TICK, r); chk(1, r, 32'h0000_0001, "ticket after reset");
        cfg_read(O_ADDR, r); chk(7, r, 32'h0000_0000, "address after reset");

        summary();
        $finish;
    end
endmodule